// File: doc/BRIEF.md
# Boolean Bit Unit

This block is the single-bit datapath of a small 8-bit controller core. It accepts one bit instruction at a time, made of a 4-bit operation code and an 8-bit bit address. It turns the bit address into a byte address and a bit position, reads the byte through a plain byte-memory port, and then either updates a one-bit carry register, writes the byte back with exactly one bit changed, or reports whether a conditional jump is taken.

The carry register is the Boolean accumulator. Every two-input logic operation takes carry as one input and puts its result back into carry. Storing a result into a memory bit is a separate move-from-carry operation. Bit addresses below 80h select a 16-byte bit window in RAM. Bit addresses from 80h upward select special-function register bytes. The fetch unit, the byte ALU and the register file sit outside this block.

Top module: `bitproc_top`

## Requirements
- R1: After reset, carry, busy, done and branch_taken are 0, and neither mem_rd_en nor mem_wr_en is asserted.
- R2: A bit address a below 80h maps to byte 20h + a[6:3] with bit position a[2:0]. So 28h is byte 25h bit 0, 77h is byte 2Eh bit 7, and 7Fh is byte 2Fh bit 7.
- R3: A bit address a of 80h or above maps to byte {a[7:3],000} with bit position a[2:0]. So 91h is byte 90h bit 1, B7h is byte B0h bit 7, and F5h is byte F0h bit 5.
- R4: An operation is accepted on a rising edge with op_valid high and busy low. mem_rd_en with the mapped byte address is driven in the next cycle. Read data is taken one cycle later, and any write-back happens in that same cycle. done pulses for one cycle after the following edge, together with the updated carry and branch_taken. busy stays high for the two cycles between acceptance and the done pulse.
- R5: Codes 0, 1 and 2 set, clear and complement carry. They make no memory access.
- R6: Codes 3, 4 and 5 set, clear and complement the addressed bit. The write-back changes only that bit, and carry is unchanged.
- R7: Code 6 loads the addressed bit into carry. Code 7 writes carry into the addressed bit.
- R8: Code 8 sets carry to carry AND bit, code 9 to carry AND NOT bit, code 10 to carry OR bit, and code 11 to carry OR NOT bit.
- R9: Code 12 raises branch_taken with done when the bit is 1, and code 13 when the bit is 0. Carry is unchanged.
- R10: An address at or above 80h whose byte slot is absent from the SFR_MAP parameter (default present: 80h, 90h, A0h, B0h, D0h, E0h, F0h) reads as 0. No memory strobe goes to that byte.
- R11: Codes 14 and 15 complete with done but change neither carry nor memory, and branch_taken stays 0.
- R12: op_valid while busy is high is ignored and produces no extra done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request |
| op_code | input | 4 | Operation code (see R5 to R11) |
| op_bitaddr | input | 8 | Bit address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| carry | output | 1 | Boolean accumulator |
| branch_taken | output | 1 | Jump condition result, valid with done |
| mem_addr | output | 8 | Byte address |
| mem_rd_en | output | 1 | Read strobe, data expected next cycle |
| mem_rdata | input | 8 | Read data |
| mem_wr_en | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |

## Verification
The done pulse, carry and branch_taken are due two edges after the accepting edge. The write-back reaches the bench memory on that same edge. The driver records the cycle number of each accepting edge and pushes an item with the expected carry, branch and due cycle. A monitor samples on falling edges and compares each done pulse with the oldest item, including its cycle. Memory bytes and strobe counters are checked only after the due cycle has passed.

// File: rtl/bitproc_pkg.sv
package bitproc_pkg;

    typedef enum logic [3:0] {
        OP_SETC  = 4'd0,
        OP_CLRC  = 4'd1,
        OP_CPLC  = 4'd2,
        OP_SETB  = 4'd3,
        OP_CLRB  = 4'd4,
        OP_CPLB  = 4'd5,
        OP_LDC   = 4'd6,
        OP_STC   = 4'd7,
        OP_ANDC  = 4'd8,
        OP_ANDNC = 4'd9,
        OP_ORC   = 4'd10,
        OP_ORNC  = 4'd11,
        OP_JSET  = 4'd12,
        OP_JCLR  = 4'd13
    } bop_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_MOD  = 2'd2
    } bst_e;

    typedef struct packed {
        bst_e       st;
        logic [3:0] op;
        logic [7:0] byte_a;
        logic [2:0] pos;
        logic       present;
        logic       cy;
        logic       done;
        logic       br;
    } bstate_t;

    function automatic logic op_needs_bit(input logic [3:0] op);
        return (op >= 4'd3) && (op <= 4'd13);
    endfunction

    function automatic logic op_writes_bit(input logic [3:0] op);
        return (op == OP_SETB) || (op == OP_CLRB) || (op == OP_CPLB) || (op == OP_STC);
    endfunction

endpackage

// File: rtl/bitproc_addr_map.sv
module bitproc_addr_map #(
    parameter logic [7:0]  RAM_BASE = 8'h20,
    parameter logic [15:0] SFR_MAP  = 16'h5455
) (
    input  logic [7:0] bitaddr,
    output logic [7:0] byte_addr,
    output logic [2:0] pos,
    output logic       present
);
    localparam int SLOTS = 16;

    logic [SLOTS-1:0] slot_hit;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign slot_hit[s] = SFR_MAP[s] && (bitaddr[6:3] == s[3:0]);
    end

    always_comb begin
        pos = bitaddr[2:0];
        if (!bitaddr[7]) begin
            byte_addr = RAM_BASE + {4'd0, bitaddr[6:3]};
            present   = 1'b1;
        end else begin
            byte_addr = {bitaddr[7:3], 3'b000};
            present   = |slot_hit;
        end
    end
endmodule

// File: rtl/bitproc_bit_alu.sv
module bitproc_bit_alu
    import bitproc_pkg::*;
(
    input  logic [3:0] op,
    input  logic       cy,
    input  logic [7:0] byte_in,
    input  logic [2:0] pos,
    input  logic       present,
    output logic       cy_next,
    output logic [7:0] byte_next,
    output logic       wr_need,
    output logic       br
);
    logic bit_v;
    logic new_bit;

    always_comb begin
        bit_v   = present ? byte_in[pos] : 1'b0;
        cy_next = cy;
        new_bit = bit_v;
        br      = 1'b0;
        case (op)
            OP_SETC:  cy_next = 1'b1;
            OP_CLRC:  cy_next = 1'b0;
            OP_CPLC:  cy_next = ~cy;
            OP_SETB:  new_bit = 1'b1;
            OP_CLRB:  new_bit = 1'b0;
            OP_CPLB:  new_bit = ~bit_v;
            OP_LDC:   cy_next = bit_v;
            OP_STC:   new_bit = cy;
            OP_ANDC:  cy_next = cy & bit_v;
            OP_ANDNC: cy_next = cy & ~bit_v;
            OP_ORC:   cy_next = cy | bit_v;
            OP_ORNC:  cy_next = cy | ~bit_v;
            OP_JSET:  br = bit_v;
            OP_JCLR:  br = ~bit_v;
            default:  ;
        endcase
        byte_next      = byte_in;
        byte_next[pos] = new_bit;
        wr_need        = present && op_writes_bit(op);
    end
endmodule

// File: rtl/bitproc_top.sv
module bitproc_top
    import bitproc_pkg::*;
#(
    parameter logic [7:0]  RAM_BASE = 8'h20,
    parameter logic [15:0] SFR_MAP  = 16'h5455
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_valid,
    input  logic [3:0] op_code,
    input  logic [7:0] op_bitaddr,
    output logic       busy,
    output logic       done,
    output logic       carry,
    output logic       branch_taken,
    output logic [7:0] mem_addr,
    output logic       mem_rd_en,
    input  logic [7:0] mem_rdata,
    output logic       mem_wr_en,
    output logic [7:0] mem_wdata
);
    localparam int WIN_BYTES = 16;

    bstate_t q, d;

    logic [7:0] map_byte;
    logic [2:0] map_pos;
    logic       map_present;
    logic       alu_cy, alu_wr, alu_br;
    logic [7:0] alu_byte;

    bitproc_addr_map #(.RAM_BASE(RAM_BASE), .SFR_MAP(SFR_MAP)) u_map (
        .bitaddr  (op_bitaddr),
        .byte_addr(map_byte),
        .pos      (map_pos),
        .present  (map_present)
    );

    bitproc_bit_alu u_alu (
        .op       (q.op),
        .cy       (q.cy),
        .byte_in  (mem_rdata),
        .pos      (q.pos),
        .present  (q.present),
        .cy_next  (alu_cy),
        .byte_next(alu_byte),
        .wr_need  (alu_wr),
        .br       (alu_br)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.br      = 1'b0;
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        mem_addr  = q.byte_a;
        mem_wdata = alu_byte;
        case (q.st)
            ST_IDLE: begin
                if (op_valid) begin
                    d.st      = ST_READ;
                    d.op      = op_code;
                    d.byte_a  = map_byte;
                    d.pos     = map_pos;
                    d.present = map_present;
                end
            end
            ST_READ: begin
                mem_rd_en = q.present && op_needs_bit(q.op);
                d.st      = ST_MOD;
            end
            ST_MOD: begin
                mem_wr_en = alu_wr;
                d.cy      = alu_cy;
                d.br      = alu_br;
                d.done    = 1'b1;
                d.st      = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, op: 4'd0, byte_a: 8'd0, pos: 3'd0,
                   present: 1'b0, cy: 1'b0, done: 1'b0, br: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign busy         = (q.st != ST_IDLE);
    assign done         = q.done;
    assign carry        = q.cy;
    assign branch_taken = q.br;

    a_r4_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(mem_rd_en) && $past(mem_addr) == mem_addr);

    a_r4_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    a_r12_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    a_r6_one_bit_changed: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $countones(mem_wdata ^ mem_rdata) <= 1);

    a_r2_ram_window: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && !mem_addr[7]) |->
        (mem_addr >= RAM_BASE) && (mem_addr < RAM_BASE + 8'(WIN_BYTES)));

    a_r9_branch_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        branch_taken |-> done);

    a_r5_carry_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (carry != $past(carry)) |-> done);
endmodule

// File: tb/bitproc_top_tb_top.sv
module bitproc_top_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = 4'd0;
    logic [7:0] op_bitaddr = 8'd0;
    logic       busy, done, carry, branch_taken;
    logic [7:0] mem_addr, mem_wdata;
    logic       mem_rd_en, mem_wr_en;
    logic [7:0] mem_rdata = 8'd0;

    logic [7:0] mem [256];
    int cyc = 0;
    int compared = 0;
    int mismatched = 0;
    int rd_count = 0;
    int wr_count = 0;
    int absent_hits = 0;
    bit finished = 0;

    logic  q_cy[$];
    logic  q_br[$];
    int    q_cyc[$];
    string q_tag[$];

    bitproc_top dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_bitaddr(op_bitaddr), .busy(busy), .done(done), .carry(carry),
        .branch_taken(branch_taken), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
        .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd_en) begin
            mem_rdata <= mem[mem_addr];
            rd_count  <= rd_count + 1;
        end
        if (mem_wr_en) begin
            mem[mem_addr] <= mem_wdata;
            wr_count      <= wr_count + 1;
        end
        if ((mem_rd_en || mem_wr_en) && mem_addr == 8'hC0)
            absent_hits <= absent_hits + 1;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compares each done pulse with the oldest scoreboard item
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q_cy.size() == 0) begin
                check("R12 unexpected done", 1, 0);
            end else begin
                string t;
                t = q_tag.pop_front();
                check({t, " carry"}, carry, q_cy.pop_front());
                check({t, " branch"}, branch_taken, q_br.pop_front());
                check({t, " R4 done cycle"}, cyc, q_cyc.pop_front());
            end
        end
    end

    task automatic poke(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        mem[a] = v;
    endtask

    // Driver: issue one operation and push its expected result
    task automatic run_op(input logic [3:0] op, input logic [7:0] a,
                          input logic ecy, input logic ebr, input string tag);
        @(negedge clk);
        op_code = op; op_bitaddr = a; op_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        q_cy.push_back(ecy); q_br.push_back(ebr);
        q_cyc.push_back(cyc + 2); q_tag.push_back(tag);
        check("R4 busy after accept", busy, 1);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL R4 watchdog actual=hung expected=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int rd0, wr0;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 carry", carry, 0);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 branch", branch_taken, 0);
        check("R1 strobes", {mem_rd_en, mem_wr_en}, 0);
        rst_n = 1'b1;

        // R5 carry-only operations, no memory access
        rd0 = rd_count;
        run_op(4'd0, 8'h00, 1, 0, "R5 set carry");
        run_op(4'd1, 8'h00, 0, 0, "R5 clear carry");
        run_op(4'd2, 8'h00, 1, 0, "R5 cpl carry");
        run_op(4'd2, 8'h00, 0, 0, "R5 cpl carry again");
        check("R5 no reads", rd_count, rd0);

        // R2 / R6 RAM window bit writes
        run_op(4'd3, 8'h28, 0, 0, "R2 set 28h");
        check("R2 R6 byte 25h", mem[8'h25], 8'h01);
        poke(8'h26, 8'h7E);
        run_op(4'd3, 8'h37, 0, 0, "R6 set 37h");
        check("R6 byte 26h others kept", mem[8'h26], 8'hFE);
        poke(8'h2E, 8'h5A);
        run_op(4'd5, 8'h77, 0, 0, "R6 cpl 77h");
        check("R2 R6 byte 2Eh", mem[8'h2E], 8'hDA);
        poke(8'h2F, 8'hFF);
        run_op(4'd4, 8'h7F, 0, 0, "R6 clr 7Fh");
        check("R2 R6 byte 2Fh", mem[8'h2F], 8'h7F);
        run_op(4'd5, 8'h00, 0, 0, "R6 cpl 00h");
        check("R2 byte 20h", mem[8'h20], 8'h01);

        // R7 moves
        run_op(4'd6, 8'h7F, 0, 0, "R7 load 7Fh");
        run_op(4'd6, 8'h77, 1, 0, "R7 load 77h");
        run_op(4'd7, 8'h91, 1, 0, "R7 R3 store 91h");
        check("R3 R7 byte 90h", mem[8'h90], 8'h02);

        // R3 SFR mapping
        poke(8'hB0, 8'h80);
        run_op(4'd1, 8'h00, 0, 0, "R3 clear carry");
        run_op(4'd6, 8'hB7, 1, 0, "R3 load B7h");
        run_op(4'd3, 8'hF5, 1, 0, "R3 set F5h");
        check("R3 byte F0h", mem[8'hF0], 8'h20);

        // R8 logic into carry (91h=1, 92h=0)
        run_op(4'd8,  8'h91, 1, 0, "R8 and 1");
        run_op(4'd8,  8'h92, 0, 0, "R8 and 0");
        run_op(4'd10, 8'h91, 1, 0, "R8 or 1");
        run_op(4'd1,  8'h00, 0, 0, "R8 clear carry");
        run_op(4'd11, 8'h92, 1, 0, "R8 or not 0");
        run_op(4'd9,  8'h91, 0, 0, "R8 and not 1");
        run_op(4'd11, 8'h91, 0, 0, "R8 or not 1");
        run_op(4'd0,  8'h00, 1, 0, "R8 set carry");
        run_op(4'd9,  8'h92, 1, 0, "R8 and not 0");

        // R9 jumps
        run_op(4'd12, 8'h91, 1, 1, "R9 jset taken");
        run_op(4'd12, 8'h92, 1, 0, "R9 jset not taken");
        run_op(4'd13, 8'h92, 1, 1, "R9 jclr taken");
        run_op(4'd13, 8'h91, 1, 0, "R9 jclr not taken");

        // R10 absent SFR slot C0h
        poke(8'hC0, 8'hFF);
        run_op(4'd6, 8'hC3, 0, 0, "R10 load absent");
        run_op(4'd0, 8'h00, 1, 0, "R10 set carry");
        run_op(4'd3, 8'hC3, 1, 0, "R10 set absent");
        run_op(4'd7, 8'hC5, 1, 0, "R10 store absent");
        check("R10 byte C0h kept", mem[8'hC0], 8'hFF);
        check("R10 no strobes", absent_hits, 0);

        // R11 undefined codes
        wr0 = wr_count;
        run_op(4'd14, 8'h28, 1, 0, "R11 code 14");
        run_op(4'd15, 8'h91, 1, 0, "R11 code 15");
        check("R11 no writes", wr_count, wr0);
        check("R11 byte 25h kept", mem[8'h25], 8'h01);

        // R12 request held while busy is ignored
        @(negedge clk);
        op_code = 4'd1; op_bitaddr = 8'h00; op_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        q_cy.push_back(0); q_br.push_back(0);
        q_cyc.push_back(cyc + 2); q_tag.push_back("R12 clear carry");
        op_code = 4'd0;
        @(negedge clk);
        op_valid = 1'b0;
        repeat (4) @(negedge clk);
        check("R12 carry after ignored op", carry, 0);
        check("R12 scoreboard empty", q_cy.size(), 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule